// File: doc/BRIEF.md
# Memory Command Priority Scheduler

This block picks at most one command per clock for a DRAM command port. It sees five kinds of candidate. A pending read and a pending write come from the command queue. A refresh request comes from the refresh timer with an urgency level, and a request to enter self-refresh comes from power management. Refresh is held back while it is only optional. As its urgency rises it moves up a fixed ladder and passes the write tier first, then the read tier.

When a read and a write are both pending, the block normally favours the read. The write goes first when two things hold: the queue flags the write as one that must go ahead of the read, or the read-return FIFO is full. Without a limit, a steady stream of reads could block an older write forever. An aging counter prevents this. It counts read and write transfers that did not serve the oldest queued command. When the count reaches a programmed limit, the oldest command is promoted above everything except a refresh at the highest urgency. The grant is registered and one-hot, and a separate strobe marks a valid grant.

Top module: `mem_cmd_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt` is all zero and `gntValid` is low.
- R2: A refresh at urgency 3 (must; `refUrg` codes: 0 none, 1 may, 2 need, 3 must) is granted ahead of every other candidate, including a promoted oldest command.
- R3: Without promotion, the priority ladder from high to low is: read/write winner, refresh at urgency 2, the remaining write, refresh at urgency 1, self-refresh entry.
- R4: When `rdReq` and `wrReq` are both high and `wrHazard` is high, the write is granted in the read tier.
- R5: When `rdReq` and `wrReq` are both high and `wrHazard` is low, the read is granted if `rdFifoFull` is low. If `rdFifoFull` is high, the write is granted.
- R6: The aging count rises by one, saturating, on each read or write grant that does not serve the oldest command (`oldestIsWr` 1 = write is oldest, 0 = read is oldest). Once the count reaches or exceeds a nonzero `agingLimit`, the oldest command, if pending, is granted ahead of both read/write tiers and refresh at urgency 2.
- R7: The aging count returns to zero in the cycle the oldest command is granted.
- R8: An `agingLimit` of zero turns promotion off.
- R9: The grant appears one clock after the requests it answers. `gnt` is one-hot or zero (bit 0 read, bit 1 write, bit 2 refresh, bit 3 self-refresh), `gntValid` is high exactly when a bit is set, and with no request the next `gnt` is zero.
- R10: Refresh at urgency 0 is never granted. Refresh at urgency 1 is granted only when no read, write or urgency-2 case applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Read command pending |
| wrReq | input | 1 | Write command pending |
| wrHazard | input | 1 | Pending write must precede the read |
| rdFifoFull | input | 1 | Read-return FIFO has no room |
| oldestIsWr | input | 1 | Oldest queued command is the write |
| refUrg | input | 2 | Refresh urgency code |
| srReq | input | 1 | Self-refresh entry request |
| agingLimit | input | CNT_W | Transfers before promotion; 0 disables |
| gnt | output | 4 | Registered one-hot grant |
| gntValid | output | 1 | Grant strobe |

## Verification
Directed sequences isolate single rules. Each refresh level is paired with each request kind, so every rung of the ladder shows its order. Read/write collisions are driven with the hazard flag and the FIFO-full flag toggled separately, to show which of the two pushes the write forward. Long read-only bursts against an old pending write, run with limits of zero, one and three, separate promotion that is disabled, promotion that fires at once, and promotion that fires after counting. Random mixes then compare every cycle against a behavioural model, which covers saturation and clearing of the aging count.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int GNT_W  = 4;
  localparam int GNT_RD = 0;
  localparam int GNT_WR = 1;
  localparam int GNT_RF = 2;
  localparam int GNT_SR = 3;

  typedef enum logic [1:0] {
    URG_NONE = 2'd0,
    URG_MAY  = 2'd1,
    URG_NEED = 2'd2,
    URG_MUST = 2'd3
  } urg_e;

  typedef struct packed {
    logic boostRd;
    logic boostWr;
  } agingCtl_t;
endpackage

// File: rtl/sched_aging_ctrl.sv
module sched_aging_ctrl
  import sched_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selRd,
  input  logic             selWr,
  input  logic             oldestIsWr,
  input  logic [CNT_W-1:0] agingLimit,
  output agingCtl_t        ctl
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] xferCnt;
  logic             oldestServed;
  logic             boostOn;

  assign oldestServed = (selRd && !oldestIsWr) || (selWr && oldestIsWr);
  assign boostOn      = (agingLimit != '0) && (xferCnt >= agingLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferCnt <= '0;
    end else if (oldestServed) begin
      xferCnt <= '0;
    end else if ((selRd || selWr) && xferCnt != CNT_MAX) begin
      xferCnt <= xferCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.boostRd = boostOn && !oldestIsWr;
    ctl.boostWr = boostOn && oldestIsWr;
  end

  // R7: serving the oldest command empties the count
  a_r7_clear_on_oldest: assert property (@(posedge clk) disable iff (!rstN)
    oldestServed |=> (xferCnt == '0));

  // R6: count moves only on a transfer
  a_r6_count_still: assert property (@(posedge clk) disable iff (!rstN)
    !(selRd || selWr) |=> $stable(xferCnt));

  // R8: zero limit never promotes
  a_r8_no_boost: assert property (@(posedge clk) disable iff (!rstN)
    (agingLimit == '0) |-> !(ctl.boostRd || ctl.boostWr));
endmodule

// File: rtl/sched_select_dp.sv
module sched_select_dp
  import sched_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdReq,
  input  logic             wrReq,
  input  logic             wrHazard,
  input  logic             rdFifoFull,
  input  logic [1:0]       refUrg,
  input  logic             srReq,
  input  agingCtl_t        ctl,
  output logic             selRd,
  output logic             selWr,
  output logic [GNT_W-1:0] gnt,
  output logic             gntValid
);
  urg_e             urg;
  logic             wrFirst;
  logic [GNT_W-1:0] nextGnt;

  assign urg     = urg_e'(refUrg);
  assign wrFirst = rdReq && wrReq && (wrHazard || rdFifoFull);

  always_comb begin
    nextGnt = '0;
    if (urg == URG_MUST)             nextGnt[GNT_RF] = 1'b1;
    else if (ctl.boostRd && rdReq)   nextGnt[GNT_RD] = 1'b1;
    else if (ctl.boostWr && wrReq)   nextGnt[GNT_WR] = 1'b1;
    else if (rdReq && !wrFirst)      nextGnt[GNT_RD] = 1'b1;
    else if (wrFirst)                nextGnt[GNT_WR] = 1'b1;
    else if (urg == URG_NEED)        nextGnt[GNT_RF] = 1'b1;
    else if (wrReq)                  nextGnt[GNT_WR] = 1'b1;
    else if (urg == URG_MAY)         nextGnt[GNT_RF] = 1'b1;
    else if (srReq)                  nextGnt[GNT_SR] = 1'b1;
  end

  assign selRd = nextGnt[GNT_RD];
  assign selWr = nextGnt[GNT_WR];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gnt      <= '0;
      gntValid <= 1'b0;
    end else begin
      gnt      <= nextGnt;
      gntValid <= (nextGnt != '0);
    end
  end

  // R9: never two grants at once
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt));

  // R9: strobe matches the grant vector
  a_r9_strobe: assert property (@(posedge clk) disable iff (!rstN)
    gntValid == (gnt != '0));

  // R9: idle request set gives an empty grant
  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!rdReq && !wrReq && !srReq && refUrg == 2'd0) |=> (gnt == '0));

  // R2: must-level refresh always wins
  a_r2_must_first: assert property (@(posedge clk) disable iff (!rstN)
    (refUrg == 2'd3) |=> gnt[GNT_RF]);

  // R10: no refresh without urgency
  a_r10_no_urg: assert property (@(posedge clk) disable iff (!rstN)
    (refUrg == 2'd0) |=> !gnt[GNT_RF]);
endmodule

// File: rtl/mem_cmd_sched.sv
module mem_cmd_sched
  import sched_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdReq,
  input  logic             wrReq,
  input  logic             wrHazard,
  input  logic             rdFifoFull,
  input  logic             oldestIsWr,
  input  logic [1:0]       refUrg,
  input  logic             srReq,
  input  logic [CNT_W-1:0] agingLimit,
  output logic [3:0]       gnt,
  output logic             gntValid
);
  agingCtl_t ctl;
  logic      selRd;
  logic      selWr;

  sched_aging_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .selRd      (selRd),
    .selWr      (selWr),
    .oldestIsWr (oldestIsWr),
    .agingLimit (agingLimit),
    .ctl        (ctl)
  );

  sched_select_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .rdReq      (rdReq),
    .wrReq      (wrReq),
    .wrHazard   (wrHazard),
    .rdFifoFull (rdFifoFull),
    .refUrg     (refUrg),
    .srReq      (srReq),
    .ctl        (ctl),
    .selRd      (selRd),
    .selWr      (selWr),
    .gnt        (gnt),
    .gntValid   (gntValid)
  );
endmodule

// File: tb/mem_cmd_sched_tb.sv
module mem_cmd_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int CNT_TOP    = (1 << CNT_W) - 1;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rdReq = 0, wrReq = 0, wrHazard = 0, rdFifoFull = 0, oldestIsWr = 0, srReq = 0;
  logic [1:0]       refUrg = 2'd0;
  logic [CNT_W-1:0] agingLimit = '0;
  logic [3:0]       gnt;
  logic             gntValid;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int mCnt  = 0;
  string phase = "";

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mem_cmd_sched #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .wrHazard(wrHazard),
    .rdFifoFull(rdFifoFull), .oldestIsWr(oldestIsWr), .refUrg(refUrg),
    .srReq(srReq), .agingLimit(agingLimit), .gnt(gnt), .gntValid(gntValid)
  );

  // Behavioural reference: returns granted kind (0 rd,1 wr,2 ref,3 sr,-1 none) and the rule used
  function automatic int pick(output string tag);
    bit promo = (agingLimit != 0) && (mCnt >= int'(agingLimit));
    bit collide = rdReq && wrReq;
    tag = "R9";
    if (refUrg == 2'd3) begin tag = "R2"; return 2; end
    if (promo && !oldestIsWr && rdReq) begin tag = "R6"; return 0; end
    if (promo && oldestIsWr && wrReq) begin tag = "R6"; return 1; end
    if (collide && wrHazard) begin tag = "R4"; return 1; end
    if (collide && rdFifoFull) begin tag = "R5"; return 1; end
    if (collide) begin tag = "R5"; return 0; end
    if (rdReq) begin tag = "R3"; return 0; end
    if (refUrg == 2'd2) begin tag = "R3"; return 2; end
    if (wrReq) begin tag = "R3"; return 1; end
    if (refUrg == 2'd1) begin tag = "R10"; return 2; end
    if (srReq) begin tag = "R3"; return 3; end
    return -1;
  endfunction

  task automatic check(input string tag, input logic [3:0] expG);
    total++;
    if (gnt !== expG || gntValid !== (expG != 0)) begin
      bad++;
      $display("FAIL %s [%s] cycle %0d gnt=%b valid=%b expected gnt=%b valid=%b",
               tag, phase, cyc, gnt, gntValid, expG, expG != 0);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input bit hz, input bit ff,
                      input bit ow, input logic [1:0] u, input bit sr);
    string tag;
    int k;
    logic [3:0] expG;
    rdReq = rd; wrReq = wr; wrHazard = hz; rdFifoFull = ff;
    oldestIsWr = ow; refUrg = u; srReq = sr;
    k = pick(tag);
    expG = (k < 0) ? 4'b0 : (4'b1 << k);
    if ((k == 0 && !ow) || (k == 1 && ow)) mCnt = 0;
    else if ((k == 0 || k == 1) && mCnt < CNT_TOP) mCnt++;
    @(posedge clk);
    @(negedge clk);
    check(tag, expG);
  endtask

  initial begin
    @(posedge clk);
    if (cyc < 0) ; // keep ordering simple
    wait (cyc >= WATCHDOG);
    bad++;
    $display("FAIL watchdog expired at cycle %0d expected finish earlier", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    phase = "R1 reset";
    repeat (3) @(negedge clk);
    check("R1", 4'b0);
    rstN = 1'b1;
    mCnt = 0;
    check("R1", 4'b0);

    // ladder with promotion off
    phase = "R3 ladder";
    agingLimit = 0;
    step(1,1,0,0,0,2'd3,1);   // R2 must beats all
    step(1,0,0,0,0,2'd2,1);   // read over need
    step(0,1,0,0,0,2'd2,1);   // need over write
    step(0,1,0,0,0,2'd1,1);   // write over may
    step(0,0,0,0,0,2'd1,1);   // R10 may over sr
    step(0,0,0,0,0,2'd0,1);   // sr alone
    step(0,0,0,0,0,2'd0,0);   // R9 idle
    step(0,0,0,0,0,2'd0,0);

    phase = "R4 R5 collide";
    step(1,1,1,0,0,2'd2,0);   // hazard: write in read tier, above need
    step(1,1,0,1,0,2'd2,0);   // fifo full: write first
    step(1,1,0,0,0,2'd2,0);   // read first
    step(1,1,1,1,1,2'd0,0);

    phase = "R8 limit0";
    agingLimit = 0;
    for (int i = 0; i < 20; i++) step(1,1,0,0,1,2'd0,0);

    phase = "R6 R7 limit3";
    agingLimit = 3;
    for (int i = 0; i < 12; i++) step(1,1,0,0,1,2'd2,0);
    step(1,1,0,0,1,2'd3,0);   // R2 must above promotion

    phase = "R6 limit1";
    agingLimit = 1;
    for (int i = 0; i < 10; i++) step(1,1,0,0,(i % 3) == 0,2'd0,0);

    phase = "R6 saturate";
    agingLimit = 8'd255;
    for (int i = 0; i < 300; i++) step(1,0,0,0,1,2'd0,0);
    step(1,1,0,0,1,2'd0,0);
    step(1,1,0,0,1,2'd0,0);

    for (int p = 0; p < 4; p++) begin
      agingLimit = (p == 0) ? 8'd0 : (p == 1) ? 8'd2 : (p == 2) ? 8'd5 : 8'd1;
      phase = "random mix";
      for (int i = 0; i < 3000; i++) begin
        int r = $urandom;
        step(r[0], r[1], r[2] & r[3], r[4], r[5], r[7:6] & {r[8], 1'b1}, r[9]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule